// File: doc/BRIEF.md
# Register Write-Protection Unlock Sequencer

This block stands in front of the configuration registers of a timekeeping peripheral. It watches a simple write bus made of a strobe, a byte address and a data word. It opens the protection only after software has written a fixed key of seven distinct byte values to seven consecutive word addresses, in one fixed order. The block reports its progress through the key as a count. It raises a registered `unlocked` flag once the last key write has landed. The protected registers use that flag to accept or refuse configuration writes.

A write that lands inside the key window but does not carry the next expected value sends the search back to the start. When that same write happens to be the first key entry, it starts a new attempt at step one instead. Writes outside the window do not touch the progress. Once the block is open it stays open. Only a synchronous `relock` pulse or the active-low reset closes it again.

Top module: `wp_unlock_seq`

## Requirements
- R1: In reset (`rst_n` low at a clock edge), `progress` becomes 0 and `unlocked` becomes 0.
- R2: The key has seven entries, consumed in this order:
  - 0xC6 to byte address 0x04
  - 0x9A to 0x08
  - 0x59 to 0x0C
  - 0xA3 to 0x10
  - 0x57 to 0x14
  - 0x67 to 0x18
  - 0xD2 to 0x1C

  A write of the next expected entry raises `progress` by one at the next clock edge.
- R3: Only bits [7:0] of `bus_wdata` take part in the key comparison. Bits above 7 may hold any value.
- R4: `unlocked` goes high at the clock edge that samples the seventh correct write, and `progress` then reads 7.
- R5: While the block is locked, a write to an address from 0x04 to 0x1C inclusive that is not the next expected entry sets `progress` to 0. If that write is the first entry (0xC6 to 0x04), `progress` becomes 1 instead.
- R6: A write to an address below 0x04 or above 0x1C leaves `progress` and `unlocked` unchanged.
- R7: In a cycle with `bus_wr` low and `relock` low, `progress` and `unlocked` keep their values.
- R8: `relock` high at a clock edge clears `progress` and `unlocked`, and it wins over a write in the same cycle.
- R9: While `unlocked` is high, no bus write changes `progress` or `unlocked`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe of the monitored bus |
| bus_addr | input | ADDR_W (12) | Byte address of the write |
| bus_wdata | input | DATA_W (32) | Write data; only bits [7:0] are compared |
| relock | input | 1 | Synchronous request to close the protection |
| unlocked | output | 1 | High while configuration writes are allowed |
| progress | output | 3 | Number of key entries accepted so far (0 to 7) |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a 32-bit data word, and the key starting at 0x04 on a 4-byte stride. The wide data word lets the bench fill bits above the key byte with noise to show they are ignored. The 12-bit address reaches both just below and well above the key window, so out-of-window writes can be mixed into a sequence in progress. A behavioural model then follows directed sequences and a long random mix of correct, wrong, foreign and relock cycles, and the design is compared against it on every clock.

// File: rtl/wp_unlock_pkg.sv
// Package: shared constants and the key byte table of the unlock sequencer.
// Assumes a key of exactly seven entries; the byte order is the unlock order.
package wp_unlock_pkg;
    localparam int KEY_LEN = 7;
    localparam int STEP_W  = $clog2(KEY_LEN + 1);

    // Returns the key byte expected at a given step; zero past the end.
    function automatic logic [7:0] key_byte(input logic [STEP_W-1:0] idx);
        case (idx)
            3'd0:    key_byte = 8'hC6;
            3'd1:    key_byte = 8'h9A;
            3'd2:    key_byte = 8'h59;
            3'd3:    key_byte = 8'hA3;
            3'd4:    key_byte = 8'h57;
            3'd5:    key_byte = 8'h67;
            3'd6:    key_byte = 8'hD2;
            default: key_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/wp_key_table.sv
// Module: gives the address and byte expected at the current step.
// Assumes key entries sit on consecutive words starting at BASE.
module wp_key_table
    import wp_unlock_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE   = 4,
    parameter int STRIDE = 4
) (
    input  logic [STEP_W-1:0] idx,
    output logic [ADDR_W-1:0] exp_addr,
    output logic [7:0]        exp_byte
);
    // Computes the expected address and key byte for idx.
    always_comb begin
        exp_addr = ADDR_W'(BASE) + ADDR_W'(STRIDE) * ADDR_W'(idx);
        exp_byte = key_byte(idx);
    end
endmodule

// File: rtl/wp_write_decode.sv
// Module: classifies a bus write against the key window and expected entry.
// Assumes only the low data byte is significant for the key.
module wp_write_decode
    import wp_unlock_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BASE   = 4,
    parameter int STRIDE = 4
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] exp_addr,
    input  logic [7:0]        exp_byte,
    output logic              in_window,
    output logic              hit_expected,
    output logic              hit_first
);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(BASE + STRIDE * (KEY_LEN - 1));

    logic [7:0] wbyte;
    logic       unused_hi;

    assign wbyte     = bus_wdata[7:0];
    assign unused_hi = &{1'b0, bus_wdata[DATA_W-1:8]};

    // Flags a window write, a match of the next entry, and a match of entry one.
    always_comb begin
        in_window    = bus_wr && (bus_addr >= WIN_LO) && (bus_addr <= WIN_HI);
        hit_expected = in_window && (bus_addr == exp_addr) && (wbyte == exp_byte);
        hit_first    = in_window && (bus_addr == WIN_LO) && (wbyte == key_byte('0));
    end
endmodule

// File: rtl/wp_step_fsm.sv
// Module: holds the step count and the registered unlocked flag.
// Assumes decode flags are valid only when a write is present.
module wp_step_fsm
    import wp_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              relock,
    input  logic              in_window,
    input  logic              hit_expected,
    input  logic              hit_first,
    output logic [STEP_W-1:0] step,
    output logic              unlocked
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(KEY_LEN - 1);

    // Advances, restarts or clears the search; holds once open.
    always_ff @(posedge clk) begin
        if (!rst_n || relock) begin
            step     <= '0;
            unlocked <= 1'b0;
        end else if (!unlocked && in_window) begin
            if (hit_expected) begin
                step     <= step + 1'b1;
                unlocked <= (step == LAST);
            end else begin
                step <= hit_first ? STEP_W'(1) : '0;
            end
        end
    end
endmodule

// File: rtl/wp_unlock_seq.sv
// Module: top of the write-protection unlock sequencer.
// Assumes one write per cycle on the monitored bus; relock is synchronous.
module wp_unlock_seq
    import wp_unlock_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BASE   = 4,
    parameter int STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              relock,
    output logic              unlocked,
    output logic [STEP_W-1:0] progress
);
    logic [ADDR_W-1:0] exp_addr;
    logic [7:0]        exp_byte;
    logic              in_window;
    logic              hit_expected;
    logic              hit_first;

    wp_key_table #(.ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)) u_table (
        .idx      (progress),
        .exp_addr (exp_addr),
        .exp_byte (exp_byte)
    );

    wp_write_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE), .STRIDE(STRIDE)) u_decode (
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .exp_addr     (exp_addr),
        .exp_byte     (exp_byte),
        .in_window    (in_window),
        .hit_expected (hit_expected),
        .hit_first    (hit_first)
    );

    wp_step_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .relock       (relock),
        .in_window    (in_window),
        .hit_expected (hit_expected),
        .hit_first    (hit_first),
        .step         (progress),
        .unlocked     (unlocked)
    );
endmodule

// File: rtl/wp_unlock_chk.sv
// Checker: temporal properties of the unlock sequencer, bound to the top.
// Assumes the default key layout (base 0x04, stride 4).
module wp_unlock_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              relock,
    input logic              unlocked,
    input logic [2:0]        progress
);
    logic outside;
    logic unused_hi;
    assign outside   = (bus_addr < ADDR_W'(4)) || (bus_addr > ADDR_W'(28));
    assign unused_hi = &{1'b0, bus_wdata[DATA_W-1:8]};

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (progress == 3'd0 && !unlocked));

    assert_open_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && bus_addr == ADDR_W'(28)
                                 && bus_wdata[7:0] == 8'hD2 && progress == 3'd6 && !relock));

    assert_open_means_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |-> progress == 3'd7);

    assert_foreign_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && outside && !relock) |=> ($stable(progress) && $stable(unlocked)));

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !relock) |=> ($stable(progress) && $stable(unlocked)));

    assert_relock_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> (progress == 3'd0 && !unlocked));

    assert_open_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && !relock) |=> unlocked);
endmodule

bind wp_unlock_seq wp_unlock_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .relock    (relock),
    .unlocked  (unlocked),
    .progress  (progress)
);

// File: tb/tb_wp_unlock_seq.sv
// Bench: behavioural reference model compared with the design on every clock.
module tb_wp_unlock_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        relock = 1'b0;
    logic        unlocked;
    logic [2:0]  progress;

    int checks = 0;
    int errors = 0;
    int m_step = 0;
    bit done = 0;
    byte unsigned keys [7] = '{8'hC6, 8'h9A, 8'h59, 8'hA3, 8'h57, 8'h67, 8'hD2};

    always #5 clk = ~clk;

    wp_unlock_seq dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .relock(relock), .unlocked(unlocked), .progress(progress)
    );

    function automatic int key_addr(int i);
        return 4 + 4 * i;
    endfunction

    // Reference model: one clock edge of the protection sequence.
    task automatic model_edge();
        int a = int'(bus_addr);
        int b = int'(bus_wdata[7:0]);
        if (!rst_n || relock) m_step = 0;
        else if (m_step == 7) m_step = 7;
        else if (bus_wr && a >= 4 && a <= 28) begin
            if (a == key_addr(m_step) && b == keys[m_step]) m_step++;
            else if (a == 4 && b == keys[0]) m_step = 1;
            else m_step = 0;
        end
    endtask

    // Drives one cycle, advances the model, then compares away from the edge.
    task automatic cyc(input logic w, input int a, input logic [31:0] d,
                       input logic rl, input string tag);
        bus_wr = w; bus_addr = 12'(a); bus_wdata = d; relock = rl;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        checks++;
        if (int'(progress) != m_step) begin
            errors++;
            $display("FAIL %s progress actual=%0d expected=%0d", tag, progress, m_step);
        end
        checks++;
        if (unlocked !== (m_step == 7)) begin
            errors++;
            $display("FAIL %s unlocked actual=%0b expected=%0b", tag, unlocked, m_step == 7);
        end
    endtask

    task automatic key_write(input int i, input logic [23:0] noise, input string tag);
        cyc(1'b1, key_addr(i), {noise, keys[i]}, 1'b0, tag);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        cyc(1'b0, 0, 0, 1'b0, "R1");
        cyc(1'b1, 4, 32'hC6, 1'b0, "R1");
        rst_n = 1'b1;
        // R2, R3, R4: full key with noise in the upper data bits
        for (int i = 0; i < 7; i++) key_write(i, 24'hA5A5A5 + 24'(i), "R2_R3_R4");
        // R9: writes after opening do not close it
        cyc(1'b1, 4, 32'h0, 1'b0, "R9");
        cyc(1'b1, 16, 32'hFF, 1'b0, "R9");
        key_write(0, 0, "R9");
        // R8: relock with a simultaneous key write
        cyc(1'b1, 4, 32'hC6, 1'b1, "R8");
        // R5: partial then wrong value in window
        for (int i = 0; i < 3; i++) key_write(i, 0, "R2");
        cyc(1'b1, 16, 32'h00, 1'b0, "R5");
        // R5: wrong write that is itself entry one
        for (int i = 0; i < 4; i++) key_write(i, 0, "R2");
        cyc(1'b1, 4, 32'hC6, 1'b0, "R5");
        // R5: right byte, wrong address
        cyc(1'b1, 12, 32'h9A, 1'b0, "R5");
        // R6 and R7: foreign writes and idle cycles inside a sequence
        for (int i = 0; i < 7; i++) begin
            key_write(i, 24'hFFFFFF, "R2");
            cyc(1'b1, 0, 32'h9A, 1'b0, "R6");
            cyc(1'b1, 32, 32'hD2, 1'b0, "R6");
            cyc(1'b1, 12'hFFC, 32'h59, 1'b0, "R6");
            cyc(1'b0, 4, 32'h0, 1'b0, "R7");
        end
        cyc(1'b0, 0, 0, 1'b1, "R8");
        // R3: upper bits equal the key but low byte wrong
        key_write(0, 0, "R2");
        cyc(1'b1, 8, 32'h9A9A9A00, 1'b0, "R3");
        // random mix of all cases
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 3) cyc(1'b0, 0, 0, 1'b1, "R8");
            else if (r < 55 && m_step < 7) key_write(m_step, 24'($urandom), "R2");
            else if (r < 70) cyc(1'b0, int'($urandom_range(0, 40)), $urandom, 1'b0, "R7");
            else cyc(1'b1, 4 * int'($urandom_range(0, 10)),
                     (r < 80) ? {24'($urandom), keys[$urandom_range(0, 6)]} : $urandom,
                     1'b0, "R5_R6_R9");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule